// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit unsigned operands and a carry-in and gives a 16-bit sum and a carry-out. It is combinational: results follow the inputs in the same time step, with no clock, no state and no latches.

The operands are split into four 4-bit slices. Each slice forms a generate bit (A AND B) and a propagate bit (A XOR B) for every position. From these and its own carry-in it forms its three inner carries as flat sums of products, and it reports a slice-wide generate and propagate. A second lookahead unit of the same form takes the four slice-wide pairs and the external carry-in. It gives the carry into slices 1 to 3 and the final carry-out, so no carry ripples from one slice to the next. The second-level generate and propagate leave the block as outputs, so that a wider adder can place a further lookahead level above it.

Every carry equation is written out term by term. No full-width `+` operator appears in the design, so the two-level structure stays visible in the netlist. With unit delays of 3 for XOR and AND gates and 2 for an AND-OR stage, the worst path is about 12 units. A 16-bit ripple chain would take about 36.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 65536 for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit result `op_a` + `op_b` + `carry_in`.
- R3: `grp_gen` is 1 exactly when `op_a` + `op_b`, with no carry-in, is at least 65536. Whenever `grp_gen` is 1, `carry_out` is 1.
- R4: `grp_prop` is 1 exactly when `op_a` XOR `op_b` is all ones (0xFFFF).
- R5: When `grp_prop` is 1, a carry-in crosses all four slices. `carry_in`=1 gives `sum_out`=0x0000 and `carry_out`=1. `carry_in`=0 gives `sum_out`=0xFFFF and `carry_out`=0.
- R6: The carry into each slice k+1 (k = 0..2) and the final carry-out come from the second-level unit. Each of them equals the slice-k carry-out, computed as slice generate OR (slice propagate AND slice carry-in). Seen at the ports, a carry made in the top bit of any slice shows up as a 1 in the lowest bit of the next slice, or in `carry_out` for slice 3.
- R7: `grp_gen` and `grp_prop` are never 1 together.
- R8: The block has no storage. Outputs reflect the current inputs and do not depend on earlier input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | Second-level group generate |
| grp_prop | output | 1 | Second-level group propagate |

## Verification
Every result is due in the same time step as the stimulus, zero cycles later, because no register lies on any path. The bench changes the inputs just after a falling clock edge and samples the outputs one nanosecond before the next rising edge, so every check sees settled logic. Each vector is compared with values the bench computes by arithmetic from the inputs. For R8, the bench applies the same vector again after very different preceding vectors and checks that the result is unchanged.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned SLICE_W   = 4;
    localparam int unsigned NUM_SLICE = 4;
    localparam int unsigned ADD_W     = SLICE_W * NUM_SLICE;

    typedef struct packed {
        logic gen;
        logic prop;
    } grp_t;
endpackage

// File: rtl/cla_bitcell.sv
module cla_bitcell (
    input  logic a_i,
    input  logic b_i,
    output logic g_o,
    output logic p_o
);
    always_comb begin
        g_o = a_i & b_i;
        p_o = a_i ^ b_i;
    end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
    input  logic [3:0] g_i,
    input  logic [3:0] p_i,
    input  logic       ci_i,
    output logic [3:0] c_o,
    output logic       gg_o,
    output logic       pg_o,
    output logic       co_o
);
    always_comb begin
        c_o[0] = ci_i;
        c_o[1] = g_i[0] | (p_i[0] & ci_i);
        c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & ci_i);
        c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
               | (p_i[2] & p_i[1] & p_i[0] & ci_i);
        pg_o   = p_i[3] & p_i[2] & p_i[1] & p_i[0];
        gg_o   = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
               | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
        co_o   = gg_o | (pg_o & ci_i);
    end

    // R7: group generate and group propagate exclude each other
    always_comb begin
        a_r7_grp_exclusive: assert (!(gg_o && pg_o))
            else $error("group generate and propagate both high");
    end
endmodule

// File: rtl/cla_slice.sv
module cla_slice
    import cla_pkg::*;
(
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic               ci_i,
    output logic [SLICE_W-1:0] s_o,
    output grp_t               grp_o,
    output logic               co_o
);
    logic [SLICE_W-1:0] g_w;
    logic [SLICE_W-1:0] p_w;
    logic [SLICE_W-1:0] c_w;
    logic               gg_w;
    logic               pg_w;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        cla_bitcell u_cell (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .g_o (g_w[i]),
            .p_o (p_w[i])
        );
    end

    cla_lookahead4 u_la (
        .g_i  (g_w),
        .p_i  (p_w),
        .ci_i (ci_i),
        .c_o  (c_w),
        .gg_o (gg_w),
        .pg_o (pg_w),
        .co_o (co_o)
    );

    always_comb begin
        s_o       = p_w ^ c_w;
        grp_o.gen  = gg_w;
        grp_o.prop = pg_w;
    end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
(
    input  logic [ADD_W-1:0] op_a,
    input  logic [ADD_W-1:0] op_b,
    input  logic             carry_in,
    output logic [ADD_W-1:0] sum_out,
    output logic             carry_out,
    output logic             grp_gen,
    output logic             grp_prop
);
    grp_t [NUM_SLICE-1:0]   slice_grp;
    logic [NUM_SLICE-1:0]   slice_g;
    logic [NUM_SLICE-1:0]   slice_p;
    logic [NUM_SLICE-1:0]   slice_co;
    logic [NUM_SLICE-1:0]   slice_ci;

    for (genvar k = 0; k < NUM_SLICE; k++) begin : g_slice
        cla_slice u_slice (
            .a_i   (op_a[k*SLICE_W +: SLICE_W]),
            .b_i   (op_b[k*SLICE_W +: SLICE_W]),
            .ci_i  (slice_ci[k]),
            .s_o   (sum_out[k*SLICE_W +: SLICE_W]),
            .grp_o (slice_grp[k]),
            .co_o  (slice_co[k])
        );
        assign slice_g[k] = slice_grp[k].gen;
        assign slice_p[k] = slice_grp[k].prop;
    end

    cla_lookahead4 u_top_la (
        .g_i  (slice_g),
        .p_i  (slice_p),
        .ci_i (carry_in),
        .c_o  (slice_ci),
        .gg_o (grp_gen),
        .pg_o (grp_prop),
        .co_o (carry_out)
    );

    // R6: the carry each slice forms itself agrees with the second-level carry
    for (genvar k = 0; k < NUM_SLICE - 1; k++) begin : g_chk
        always_comb begin
            a_r6_slice_carry_match: assert (slice_co[k] == slice_ci[k+1])
                else $error("slice %0d carry mismatch", k);
        end
    end

    always_comb begin
        a_r6_last_carry_match: assert (slice_co[NUM_SLICE-1] == carry_out)
            else $error("final carry mismatch");
        // R3
        a_r3_gen_forces_carry: assert (!grp_gen || carry_out)
            else $error("generate without carry-out");
        // R5
        a_r5_full_propagate: assert (!grp_prop ||
            ((carry_out == carry_in) &&
             (sum_out == (carry_in ? {ADD_W{1'b0}} : {ADD_W{1'b1}}))))
            else $error("full propagate result wrong");
    end
endmodule

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb;
    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out, grp_gen, grp_prop;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cla16_adder u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .grp_gen   (grp_gen),
        .grp_prop  (grp_prop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h",
                     req, op_a, op_b, carry_in, act, exp);
        end
    endtask

    // drive after falling edge, sample 1 ns before next rising edge
    task automatic run(input logic [15:0] a, input logic [15:0] b, input logic ci);
        logic [16:0] full;
        logic [16:0] nocin;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci;
        #4;
        full  = {1'b0, a} + {1'b0, b} + {16'b0, ci};
        nocin = {1'b0, a} + {1'b0, b};
        chk("R1", {16'b0, sum_out}, {16'b0, full[15:0]});
        chk("R2", {31'b0, carry_out}, {31'b0, full[16]});
        chk("R3", {31'b0, grp_gen}, {31'b0, nocin[16]});
        chk("R4", {31'b0, grp_prop}, {31'b0, ((a ^ b) == 16'hFFFF)});
        chk("R7", {31'b0, grp_gen & grp_prop}, 32'd0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ra, rb;
        logic [15:0] keep_sum;
        logic        keep_co;
        // R8: outputs at time zero follow the all-zero inputs
        #4;
        chk("R8", {15'b0, carry_out, sum_out}, 32'd0);

        // near-exhaustive: every nibble pair and carry-in in each slice,
        // other slices set to propagate so carries cross them
        for (int s = 0; s < 4; s++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    for (int c = 0; c < 2; c++) begin
                        ra = 16'h5555; rb = 16'hAAAA;
                        ra[s*4 +: 4] = x[3:0];
                        rb[s*4 +: 4] = y[3:0];
                        run(ra, rb, c[0]);
                    end

        // R5: full propagate, both carry-in values
        run(16'hFFFF, 16'h0000, 1'b1);
        chk("R5", {15'b0, carry_out, sum_out}, {15'b0, 1'b1, 16'h0000});
        run(16'h1234, 16'hEDCB, 1'b0);
        chk("R5", {15'b0, carry_out, sum_out}, {15'b0, 1'b0, 16'hFFFF});

        // R6: carry from top bit of each slice lands in next slice / carry_out
        run(16'h000F, 16'h0001, 1'b0);
        chk("R6", {16'b0, sum_out}, 32'h0010);
        run(16'h00F0, 16'h0010, 1'b0);
        chk("R6", {16'b0, sum_out}, 32'h0100);
        run(16'h0F00, 16'h0100, 1'b0);
        chk("R6", {16'b0, sum_out}, 32'h1000);
        run(16'hF000, 16'h1000, 1'b0);
        chk("R6", {15'b0, carry_out, sum_out}, {15'b0, 1'b1, 16'h0000});

        // R3: generate with no carry-in
        run(16'h8000, 16'h8000, 1'b0);
        chk("R3", {30'b0, grp_gen, carry_out}, 32'd3);
        run(16'hFFFF, 16'hFFFF, 1'b1);

        // random vectors
        for (int i = 0; i < 3000; i++)
            run(16'($urandom), 16'($urandom), 1'($urandom));

        // R8: same vector after very different history gives same result
        run(16'hA5C3, 16'h3C5A, 1'b1);
        keep_sum = sum_out; keep_co = carry_out;
        run(16'hFFFF, 16'hFFFF, 1'b1);
        run(16'h0000, 16'h0000, 1'b0);
        run(16'hA5C3, 16'h3C5A, 1'b1);
        chk("R8", {15'b0, carry_out, sum_out}, {15'b0, keep_co, keep_sum});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule